// File: doc/BRIEF.md
# I/O Cycle Bus Route Decoder

This block sits in a legacy I/O bridge and chooses a destination for each I/O cycle. The destination is the internal ISA-style bus, the LPC interface, or no bus at all. The cycle's address is compared with a set of fixed legacy port ranges and with ten programmable base/size windows that are supplied from outside the block. The hit with the lowest index chooses which enable bit applies. That enable bit is combined with a global polarity bit to pick the destination. The same polarity bit also controls where cycles that hit no range are sent.

A 32-bit routing register holds the enable bits, the polarity bit and a ROM-forwarding enable. A small DMA-source register decides, for each of three request channels, whether the channel sees its internal request or the shared LPC request line. Both registers are written through a byte-enabled port and read back through a combinational read port. The route decision is registered and appears one cycle after the address strobe.

Top module: `io_route_decoder`

## Requirements
- R1: After reset, both registers read zero, and `route_valid`, `isa_sel`, `lpc_sel`, `none_sel`, `multi_hit` and `rom_lpc` are low.
- R2: A write to the routing register (`cfg_addr`=0) updates only the bytes whose `cfg_be` bit is set. Bits 31:18 ignore writes and read as zero.
- R3: A cycle presented with `io_valid` high at a clock edge produces `route_valid` high at the next edge. At that edge exactly one of `isa_sel`/`lpc_sel`/`none_sel` is high. Without a strobe, all of them are low.
- R4: The fixed ranges and their enable bits are: 070h–073h uses bit 17; 04Eh–04Fh uses bit 14; 02Eh–02Fh uses bit 13; 388h–389h uses bit 12; 062h and 066h use bit 11; 060h and 064h use bit 10.
- R5: A claimed cycle goes to LPC when its enable bit differs from the global bit (bit 16), and to ISA when the two bits are equal.
- R6: A cycle that hits no range goes to LPC when bit 16 is 1, and to no bus (`none_sel`) when bit 16 is 0.
- R7: Programmable window i (i = 0..9) covers base_i ≤ addr < base_i + size_i and uses enable bit i. A window with size 0 never hits.
- R8: When two or more ranges hit, `multi_hit` is raised together with the decision, and the hit with the lowest enable-bit index chooses the route.
- R9: `rom_lpc` rises with the decision when `rom_req` was high with the strobe and bit 15 is 1. Bit 15 has no effect on address routing.
- R10: In the DMA-source register (`cfg_addr`=1), bit c (c = 0..2) set to 1 makes `drq_out[c]` follow `ldrq`. Bit c set to 0 makes `drq_out[c]` follow `drq_isa[c]`.
- R11: The DMA-source register keeps only bits 2:0, which are written through byte lane 0. Its bits 31:3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 routing, 1 DMA source |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| io_valid | input | 1 | I/O cycle address strobe |
| io_addr | input | 16 | I/O cycle address |
| rom_req | input | 1 | Cycle targets the ROM range |
| prog_base | input | 160 | Ten packed 16-bit window bases |
| prog_size | input | 160 | Ten packed 16-bit window sizes |
| route_valid | output | 1 | Decision valid |
| isa_sel | output | 1 | Route to internal ISA bus |
| lpc_sel | output | 1 | Route to LPC |
| none_sel | output | 1 | Route to no bus |
| multi_hit | output | 1 | More than one range hit |
| rom_lpc | output | 1 | ROM cycle forwarded to LPC |
| drq_isa | input | 3 | Internal DMA requests |
| ldrq | input | 1 | Shared LPC DMA request |
| drq_out | output | 3 | Selected DMA requests |

## Verification
The bench runs all four combinations of an enable bit and the global bit against claimed and unclaimed ports. A design with an inverted XOR would send claimed keyboard cycles to the wrong bus. A design that reads the unclaimed policy backwards would send stray cycles to ISA or drop them when they should reach LPC. The bench probes both endpoints of each fixed range and the addresses one step outside them, where an off-by-one comparator would claim or miss a port. It overlaps a programmable window with a fixed range and with another window; a design with reversed priority would pick the higher index and would not flag the overlap. It also writes all ones and partial byte lanes, which shows whether reserved bits are stored or whether disabled lanes are overwritten.

// File: rtl/io_route_pkg.sv
package io_route_pkg;
    localparam int CFG_W    = 32;
    localparam int SRC_BITS = 18;
    localparam int GLB_BIT  = 16;
    localparam int ROM_BIT  = 15;
    localparam logic [CFG_W-1:0] ROUTE_WMASK = 32'h0003_FFFF;

    typedef struct packed {
        logic valid;
        logic isa;
        logic lpc;
        logic none;
        logic multi;
        logic rom;
    } route_t;
endpackage

// File: rtl/io_route_cfg.sv
module io_route_cfg
    import io_route_pkg::*;
#(
    parameter int NDMA = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [3:0]       wr_be,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] route_q,
    output logic [NDMA-1:0]  dma_q
);
    localparam int NBYTES = CFG_W / 8;

    typedef struct packed {
        logic [CFG_W-1:0] route;
        logic [NDMA-1:0]  dma;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [CFG_W-1:0] merged;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : st_q.route[b*8 +: 8];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_sel) begin
            st_d.route = merged & ROUTE_WMASK;
        end
        if (wr_en && wr_sel && wr_be[0]) begin
            st_d.dma = wr_data[NDMA-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign route_q = st_q.route;
    assign dma_q   = st_q.dma;
endmodule

// File: rtl/io_fixed_match.sv
module io_fixed_match
    import io_route_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]       addr,
    output logic [SRC_BITS-1:0] hit
);
    always_comb begin
        hit     = '0;
        hit[17] = (addr >= AW'(16'h070)) && (addr <= AW'(16'h073));
        hit[14] = (addr == AW'(16'h04E)) || (addr == AW'(16'h04F));
        hit[13] = (addr == AW'(16'h02E)) || (addr == AW'(16'h02F));
        hit[12] = (addr == AW'(16'h388)) || (addr == AW'(16'h389));
        hit[11] = (addr == AW'(16'h062)) || (addr == AW'(16'h066));
        hit[10] = (addr == AW'(16'h060)) || (addr == AW'(16'h064));
    end
endmodule

// File: rtl/io_range_match.sv
module io_range_match #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    output logic          hit
);
    logic [AW:0] offs;
    assign offs = {1'b0, addr} - {1'b0, base};
    assign hit  = (size != '0) && (addr >= base) && (offs < {1'b0, size});
endmodule

// File: rtl/io_route_decoder.sv
module io_route_decoder
    import io_route_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NPROG = 10,
    parameter int NDMA  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              io_valid,
    input  logic [AW-1:0]     io_addr,
    input  logic              rom_req,
    input  logic [NPROG*AW-1:0] prog_base,
    input  logic [NPROG*AW-1:0] prog_size,
    output logic              route_valid,
    output logic              isa_sel,
    output logic              lpc_sel,
    output logic              none_sel,
    output logic              multi_hit,
    output logic              rom_lpc,
    input  logic [NDMA-1:0]   drq_isa,
    input  logic              ldrq,
    output logic [NDMA-1:0]   drq_out
);
    localparam int IDX_W = $clog2(SRC_BITS);

    logic [CFG_W-1:0]    route_q;
    logic [NDMA-1:0]     dma_q;
    logic [SRC_BITS-1:0] fixed_hit;
    logic [NPROG-1:0]    prog_hit;
    logic [SRC_BITS-1:0] hit_vec;

    io_route_cfg #(.NDMA(NDMA)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_addr),
        .wr_be   (cfg_be),
        .wr_data (cfg_wdata),
        .route_q (route_q),
        .dma_q   (dma_q)
    );

    io_fixed_match #(.AW(AW)) u_fixed (
        .addr (io_addr),
        .hit  (fixed_hit)
    );

    for (genvar i = 0; i < NPROG; i++) begin : g_prog
        io_range_match #(.AW(AW)) u_rng (
            .addr (io_addr),
            .base (prog_base[i*AW +: AW]),
            .size (prog_size[i*AW +: AW]),
            .hit  (prog_hit[i])
        );
    end

    always_comb begin
        hit_vec = fixed_hit;
        for (int i = 0; i < NPROG; i++) begin
            hit_vec[i] = prog_hit[i];
        end
        hit_vec[GLB_BIT] = 1'b0;
        hit_vec[ROM_BIT] = 1'b0;
    end

    route_t st_d, st_q;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    logic             glb;
    logic             claim_lpc;

    always_comb begin
        win_idx = '0;
        for (int i = SRC_BITS - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
        any_hit   = |hit_vec;
        glb       = route_q[GLB_BIT];
        claim_lpc = route_q[win_idx] ^ glb;

        st_d = '0;
        if (io_valid) begin
            st_d.valid = 1'b1;
            st_d.multi = $countones(hit_vec) > 1;
            st_d.rom   = rom_req & route_q[ROM_BIT];
            if (any_hit) begin
                st_d.lpc = claim_lpc;
                st_d.isa = !claim_lpc;
            end else begin
                st_d.lpc  = glb;
                st_d.none = !glb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign route_valid = st_q.valid;
    assign isa_sel     = st_q.isa;
    assign lpc_sel     = st_q.lpc;
    assign none_sel    = st_q.none;
    assign multi_hit   = st_q.multi;
    assign rom_lpc     = st_q.rom;

    for (genvar c = 0; c < NDMA; c++) begin : g_drq
        assign drq_out[c] = dma_q[c] ? ldrq : drq_isa[c];
    end

    assign cfg_rdata = cfg_addr ? {{(CFG_W-NDMA){1'b0}}, dma_q} : route_q;
endmodule

// File: rtl/io_route_chk.sv
module io_route_chk #(
    parameter int NDMA = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_addr,
    input logic [31:0]     cfg_rdata,
    input logic            io_valid,
    input logic            rom_req,
    input logic            route_valid,
    input logic            isa_sel,
    input logic            lpc_sel,
    input logic            none_sel,
    input logic            multi_hit,
    input logic            rom_lpc,
    input logic [NDMA-1:0] drq_isa,
    input logic            ldrq,
    input logic [NDMA-1:0] drq_out
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $countones({isa_sel, lpc_sel, none_sel}) == 1); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !route_valid |-> !(isa_sel || lpc_sel || none_sel || multi_hit || rom_lpc)); // R3

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |=> route_valid); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |=> !route_valid); // R3

    AST_ROM_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_valid && rom_req) |=> !rom_lpc); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_addr |-> cfg_rdata[31:18] == '0); // R2

    AST_DMA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr |-> cfg_rdata[31:NDMA] == '0); // R11

    AST_DRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (drq_isa == '0 && !ldrq) |-> drq_out == '0); // R10
endmodule

bind io_route_decoder io_route_chk #(.NDMA(NDMA)) u_chk (.*);

// File: tb/tb_io_route_decoder.sv
module tb_io_route_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic         cfg_addr = 1'b0;
    logic [3:0]   cfg_be = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic         io_valid = 1'b0;
    logic [15:0]  io_addr = '0;
    logic         rom_req = 1'b0;
    logic [159:0] prog_base;
    logic [159:0] prog_size;
    logic         route_valid, isa_sel, lpc_sel, none_sel, multi_hit, rom_lpc;
    logic [2:0]   drq_isa = '0;
    logic         ldrq = 1'b0;
    logic [2:0]   drq_out;

    logic [15:0] pb [10];
    logic [15:0] ps [10];
    logic [31:0] shadow = '0;

    always_comb begin
        for (int i = 0; i < 10; i++) begin
            prog_base[i*16 +: 16] = pb[i];
            prog_size[i*16 +: 16] = ps[i];
        end
    end

    always #2.5 clk = ~clk;

    io_route_decoder dut (.*);

    int checks = 0;
    int fails  = 0;
    logic [4:0] expq [$];
    string      tagq [$];
    logic       done = 1'b0;

    function automatic logic [4:0] model(input logic [15:0] a, input logic [31:0] c,
                                         input logic rom);
        logic [17:0] h;
        int win;
        int n;
        logic l;
        h = '0;
        h[17] = a >= 16'h70 && a <= 16'h73;
        h[14] = a == 16'h4E || a == 16'h4F;
        h[13] = a == 16'h2E || a == 16'h2F;
        h[12] = a == 16'h388 || a == 16'h389;
        h[11] = a == 16'h62 || a == 16'h66;
        h[10] = a == 16'h60 || a == 16'h64;
        for (int i = 0; i < 10; i++) begin
            h[i] = ps[i] != 0 && a >= pb[i] && ({1'b0, a} < {1'b0, pb[i]} + {1'b0, ps[i]});
        end
        win = -1;
        n = 0;
        for (int i = 17; i >= 0; i--) begin
            if (h[i]) begin
                win = i;
                n++;
            end
        end
        if (win >= 0) begin
            l = c[win] ^ c[16];
            return {!l, l, 1'b0, n > 1, rom & c[15]};
        end
        return {1'b0, c[16], !c[16], 1'b0, rom & c[15]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] a, input logic rom, input string tag);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        io_valid  = 1'b1;
        io_addr   = a;
        rom_req   = rom;
        expq.push_back(model(a, shadow, rom));
        tagq.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        io_valid = 1'b0;
        rom_req  = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        io_valid  = 1'b0;
        cfg_wr_en = 1'b1;
        cfg_addr  = sel;
        cfg_wdata = d;
        cfg_be    = be;
        if (!sel) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) shadow[b*8 +: 8] = d[b*8 +: 8];
            shadow &= 32'h0003_FFFF;
        end
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = sel;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    // Monitor: pops one expected item per valid decision
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (route_valid) begin
                if (expq.size() == 0) begin
                    check("R3 unexpected decision", 1, 0);
                end else begin
                    logic [4:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(t, {27'd0, isa_sel, lpc_sel, none_sel, multi_hit, rom_lpc},
                          {27'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 10; i++) begin
            pb[i] = '0;
            ps[i] = '0;
        end
        pb[0] = 16'h3F8; ps[0] = 16'd8;
        pb[2] = 16'h2F8; ps[2] = 16'd8;
        pb[6] = 16'h3F0; ps[6] = 16'd6;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 outputs", {26'd0, route_valid, isa_sel, lpc_sel, none_sel, multi_hit, rom_lpc}, 0);
        rd(1'b0, 32'h0, "R1 route reg");
        rd(1'b1, 32'h0, "R1 dma reg");

        // R5/R6 with global bit 0, enables 0
        issue(16'h060, 1'b0, "R5 kbc isa 00");
        issue(16'h100, 1'b0, "R6 unclaimed none");
        issue(16'h3F8, 1'b0, "R7 window0 start");
        issue(16'h3FF, 1'b0, "R7 window0 end");
        issue(16'h3F6, 1'b0, "R7 window6 past end unclaimed");
        idle();

        // R4 range edges, with all fixed enables set, glb 0 -> claimed = lpc
        wr(1'b0, 32'h0002_7C00, 4'b1111);
        issue(16'h070, 1'b0, "R4 rtc low");
        issue(16'h073, 1'b0, "R4 rtc high");
        issue(16'h074, 1'b0, "R4 rtc past");
        issue(16'h06F, 1'b0, "R4 rtc before");
        issue(16'h04E, 1'b0, "R4 alt cfg");
        issue(16'h02F, 1'b0, "R4 cfg");
        issue(16'h030, 1'b0, "R4 cfg past");
        issue(16'h389, 1'b0, "R4 fm");
        issue(16'h066, 1'b0, "R4 acpi");
        issue(16'h063, 1'b0, "R4 acpi gap");
        issue(16'h064, 1'b0, "R4 kbc");
        idle();

        // R5 enable 1 glb 1 -> isa; R6 unclaimed -> lpc
        wr(1'b0, 32'h0001_0400, 4'b1111);
        issue(16'h064, 1'b0, "R5 kbc isa 11");
        issue(16'h062, 1'b0, "R5 acpi lpc 01");
        issue(16'h200, 1'b0, "R6 unclaimed lpc");
        idle();

        // R8 overlaps
        pb[9] = 16'h060; ps[9] = 16'd4;
        pb[3] = 16'h3FC; ps[3] = 16'd4;
        wr(1'b0, 32'h0000_0008, 4'b1111);
        issue(16'h3FD, 1'b0, "R8 win0 over win3");
        issue(16'h062, 1'b0, "R8 win9 over acpi");
        issue(16'h2FA, 1'b0, "R7 window2");
        idle();
        ps[9] = '0; ps[3] = '0;

        // R9 rom forwarding, bit15 does not touch routing
        wr(1'b0, 32'h0000_8000, 4'b1111);
        issue(16'h100, 1'b1, "R9 rom forwarded");
        issue(16'h060, 1'b0, "R9 no rom req");
        wr(1'b0, 32'h0000_0000, 4'b1111);
        issue(16'h100, 1'b1, "R9 rom disabled");
        idle();

        // R2 reserved and byte lanes
        wr(1'b0, 32'hFFFF_FFFF, 4'b1111);
        rd(1'b0, 32'h0003_FFFF, "R2 reserved zero");
        wr(1'b0, 32'h0000_0000, 4'b0001);
        rd(1'b0, 32'h0003_FF00, "R2 byte lane");
        wr(1'b0, 32'h0000_0000, 4'b0100);
        rd(1'b0, 32'h0000_FF00, "R2 lane two");

        // R10/R11 DMA source
        wr(1'b1, 32'hFFFF_FFFF, 4'b1110);
        rd(1'b1, 32'h0, "R11 lane0 needed");
        wr(1'b1, 32'hFFFF_FFFD, 4'b0001);
        rd(1'b1, 32'h5, "R11 reserved zero");
        @(negedge clk);
        drq_isa = 3'b010; ldrq = 1'b1;
        #1;
        check("R10 mixed ldrq", {29'd0, drq_out}, 32'h7);
        @(negedge clk);
        drq_isa = 3'b111; ldrq = 1'b0;
        #1;
        check("R10 mixed isa", {29'd0, drq_out}, 32'h2);
        @(negedge clk);
        drq_isa = 3'b101; ldrq = 1'b0;
        #1;
        check("R10 isa ignored", {29'd0, drq_out}, 32'h0);

        repeat (4) @(negedge clk);
        check("R3 queue drained", expq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule